// File: doc/BRIEF.md
# Shared-Line Interrupt Arm Controller

This block sits inside one adapter among several that share a single open-drain interrupt line. The line is pulled high by a resistor when nobody requests service. To ask for service, the adapter pulls the line low for a short, fixed pulse rather than holding a level. The interrupt controller that receives the line arms on the falling edge of that pulse and takes the interrupt on the rising edge. The block produces only the enable for the low-side driver: when `pull_low` is high, the pad drives the line to zero; otherwise the pad floats.

A wired line that carries pulses can merge two requests that arrive together. The block prevents this with a disarm and rearm protocol. Once any adapter on the line has pulsed it, every adapter, this one included, stops issuing requests. Each adapter stays silent until software writes to the rearm I/O address for the level. That address is `0x2F0 + LEVEL`, with LEVEL from 2 to 7. Every adapter on the level decodes the same write. If an adapter's own condition is still active when the rearm arrives, it pulses again, so a request that lost a collision is reissued.

The controller has three states:
- **ARMED**: the block is allowed to request.
- **PULSE**: the block is pulling the line low.
- **DISARMED**: the block waits for a rearm.

The transitions are:
- `req_fire` (ARMED to PULSE)
- `line_seen_low` (ARMED to DISARMED)
- `pulse_done` and `pulse_abort` (PULSE to DISARMED)
- `rearm_hit` (DISARMED to ARMED)

Top module: `shared_irq_arm`

## Requirements
- R1: After reset, `pull_low` is 0 and the block is in ARMED.
- R2: In ARMED, if the block samples `line_high`=1 with `irq_enable`=1 and `irq_cond`=1, it raises `pull_low` in the next cycle. `pull_low` then stays high for exactly PULSE_LEN cycles (default 1).
- R3: After its own pulse ends, the block holds `pull_low` at 0 whatever `irq_cond` does, until a rearm write.
- R4: In ARMED, sampling `line_high`=0 moves the block to DISARMED. This holds even when a request of its own is ready in the same cycle, so that request is not issued.
- R5: A rearm write is a one-cycle `io_wr`=1 with `io_addr` equal to 0x2F0 + LEVEL (LEVEL=3 by default, so 0x2F3). It moves DISARMED to ARMED. A write to any other address has no effect.
- R6: If `irq_cond` and `irq_enable` are high at a rearm, `pull_low` rises two cycles after the rearm write cycle: one cycle in ARMED, then PULSE.
- R7: With `irq_enable`=0 the block never drives the line. Clearing `irq_enable` during a pulse releases the line at once and ends in DISARMED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_cond | input | 1 | Adapter's internal interrupt condition (level) |
| irq_enable | input | 1 | Interrupt enable bit of the adapter |
| line_high | input | 1 | Synchronously sampled level of the shared line (1 = floating high) |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | ADDR_W (16) | I/O write address |
| pull_low | output | 1 | Enable for the open-drain driver; 1 pulls the shared line low |

## Verification
The assertions assume that `line_high` is already synchronous to `clk`. They also assume that it reflects both this block's own `pull_low` and every other driver on the line, and that `io_wr` lasts one cycle per write. The bench models the line as the wired AND of this block's driver and a second, simulated adapter. It changes every input only just after the falling clock edge and issues each rearm as a single-cycle strobe. Cases where another adapter pulls the line in the same cycle as a local request are created on purpose. This is how the bench reaches the priority rule of R4.

// File: rtl/shared_irq_pkg.sv
package shared_irq_pkg;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_PULSE    = 2'd1,
        ST_DISARMED = 2'd2
    } arm_state_t;

    localparam int unsigned REARM_BASE_ADDR = 32'h0000_02F0;
    localparam int unsigned LEVEL_MIN       = 2;
    localparam int unsigned LEVEL_MAX       = 7;

endpackage

// File: rtl/sirq_rearm_decode.sv
module sirq_rearm_decode #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEVEL  = 3
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              rearm_hit
);
    import shared_irq_pkg::*;

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REARM_BASE_ADDR + LEVEL);

    generate
        if (LEVEL >= LEVEL_MIN && LEVEL <= LEVEL_MAX) begin : g_level_ok
            assign rearm_hit = io_wr && (io_addr == HIT_ADDR);
        end else begin : g_level_none
            // An unsupported level has no rearm address: the block never rearms.
            assign rearm_hit = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/sirq_pulse_timer.sv
module sirq_pulse_timer #(
    parameter int unsigned PULSE_LEN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN - 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= LOAD_VAL;
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

    // A freshly loaded pulse never reports done before its first drive cycle.
    assert_timer_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remain == LOAD_VAL));

endmodule

// File: rtl/sirq_arm_fsm.sv
module sirq_arm_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_cond,
    input  logic irq_enable,
    input  logic line_high,
    input  logic rearm_hit,
    input  logic pulse_expired,
    output logic pulse_load,
    output logic pulse_run,
    output logic drive_low
);
    import shared_irq_pkg::*;

    arm_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_ARMED: begin
                if (!line_high)                   state_nx = ST_DISARMED; // line_seen_low
                else if (irq_enable && irq_cond)  state_nx = ST_PULSE;    // req_fire
            end
            ST_PULSE: begin
                if (pulse_expired || !irq_enable) state_nx = ST_DISARMED; // pulse_done / pulse_abort
            end
            ST_DISARMED: begin
                if (rearm_hit)                    state_nx = ST_ARMED;    // rearm_hit
            end
            default:                              state_nx = ST_DISARMED;
        endcase
    end

    always_comb begin
        pulse_load = (state == ST_ARMED) && (state_nx == ST_PULSE);
        pulse_run  = (state == ST_PULSE);
        drive_low  = (state == ST_PULSE) && irq_enable;
    end

    assert_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && line_high && irq_enable && irq_cond) |=> drive_low || !irq_enable);

    assert_holdoff_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISARMED && !rearm_hit) |=> !drive_low);

    assert_disarm_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !line_high) |=> (state == ST_DISARMED));

    assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISARMED && rearm_hit) |=> (state == ST_ARMED));

    assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_enable && state != ST_PULSE) |=> !drive_low);

endmodule

// File: rtl/shared_irq_arm.sv
module shared_irq_arm #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned LEVEL     = 3,
    parameter int unsigned PULSE_LEN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_cond,
    input  logic              irq_enable,
    input  logic              line_high,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              pull_low
);
    logic rearm_hit;
    logic pulse_load;
    logic pulse_run;
    logic pulse_expired;

    sirq_rearm_decode #(.ADDR_W(ADDR_W), .LEVEL(LEVEL)) i_decode (
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .rearm_hit (rearm_hit)
    );

    sirq_pulse_timer #(.PULSE_LEN(PULSE_LEN)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pulse_load),
        .run     (pulse_run),
        .expired (pulse_expired)
    );

    sirq_arm_fsm i_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_cond      (irq_cond),
        .irq_enable    (irq_enable),
        .line_high     (line_high),
        .rearm_hit     (rearm_hit),
        .pulse_expired (pulse_expired),
        .pulse_load    (pulse_load),
        .pulse_run     (pulse_run),
        .drive_low     (pull_low)
    );

endmodule

// File: tb/test_shared_irq_arm.sv
module test_shared_irq_arm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_cond = 1'b0;
    logic        irq_enable = 1'b0;
    logic        other_pull = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic        pull_low;
    logic        line_high;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign line_high = !(pull_low || other_pull);

    shared_irq_arm i_shared_irq_arm (
        .clk(clk), .rst_n(rst_n), .irq_cond(irq_cond), .irq_enable(irq_enable),
        .line_high(line_high), .io_wr(io_wr), .io_addr(io_addr), .pull_low(pull_low)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pull_low=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    // Single-cycle rearm write; returns at the negedge after the write cycle.
    task automatic write_io(input logic [15:0] a);
        io_wr = 1'b1; io_addr = a;
        nedge();
        io_wr = 1'b0; io_addr = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) nedge();
        chk("R1 reset", pull_low, 1'b0);
        rst_n = 1'b1;
        nedge();
        chk("R1 idle after reset", pull_low, 1'b0);
    endtask

    task automatic t_request();
        irq_enable = 1'b1; irq_cond = 1'b1;
        nedge();
        chk("R2 pulse start", pull_low, 1'b1);
        nedge();
        chk("R2 pulse one cycle", pull_low, 1'b0);
        for (int i = 0; i < 4; i++) begin
            nedge();
            chk("R3 hold-off", pull_low, 1'b0);
        end
    endtask

    task automatic t_wrong_addr();
        write_io(16'h02F4);
        chk("R5 wrong addr", pull_low, 1'b0);
        write_io(16'h02F2);
        for (int i = 0; i < 3; i++) begin
            chk("R5 wrong addr stays disarmed", pull_low, 1'b0);
            nedge();
        end
    endtask

    task automatic t_reissue();
        write_io(16'h02F3);
        chk("R6 armed cycle", pull_low, 1'b0);
        nedge();
        chk("R6 reissue pulse", pull_low, 1'b1);
        nedge();
        chk("R3 pulse ended", pull_low, 1'b0);
    endtask

    task automatic t_other_adapter();
        irq_cond = 1'b0;
        write_io(16'h02F3);
        nedge();
        chk("R5 armed idle", pull_low, 1'b0);
        other_pull = 1'b1;
        nedge();
        other_pull = 1'b0;
        irq_cond = 1'b1;
        for (int i = 0; i < 3; i++) begin
            nedge();
            chk("R4 disarmed by other adapter", pull_low, 1'b0);
        end
        write_io(16'h02F3);
        nedge();
        chk("R6 pulse after rearm", pull_low, 1'b1);
        nedge();
    endtask

    task automatic t_collision();
        irq_cond = 1'b0;
        write_io(16'h02F3);
        nedge();
        irq_cond = 1'b1; other_pull = 1'b1;
        nedge();
        other_pull = 1'b0;
        chk("R4 collision no pulse", pull_low, 1'b0);
        nedge();
        chk("R4 collision still quiet", pull_low, 1'b0);
        write_io(16'h02F3);
        chk("R6 armed after collision", pull_low, 1'b0);
        nedge();
        chk("R6 lost request reissued", pull_low, 1'b1);
        nedge();
    endtask

    task automatic t_enable();
        irq_enable = 1'b0; irq_cond = 1'b1;
        write_io(16'h02F3);
        for (int i = 0; i < 4; i++) begin
            chk("R7 disabled never drives", pull_low, 1'b0);
            nedge();
        end
        irq_enable = 1'b1;
        nedge();
        chk("R2 pulse on enable", pull_low, 1'b1);
        irq_enable = 1'b0;
        #1;
        chk("R7 release on disable", pull_low, 1'b0);
        nedge();
        irq_enable = 1'b1;
        nedge();
        chk("R7 aborted pulse leaves disarmed", pull_low, 1'b0);
    endtask

    initial begin
        nedge();
        t_reset();
        t_request();
        t_wrong_addr();
        t_reissue();
        t_other_adapter();
        t_collision();
        t_enable();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule